// File: doc/BRIEF.md
# Per-Byte Framed SPI Parameter Transmitter

This block is an SPI master that delivers one fixed six-byte parameter frame to a waveform synthesizer. A single-cycle commit strobe captures an 8-bit amplitude code, an 8-bit waveform code and seven decimal frequency digits. The block then sends the frame without further help from its driver. The frequency digits are packed two at a time into binary bytes, and the least significant pair goes first.

Every byte is framed by its own chip-select pulse. The select line goes low, eight bits are shifted MSB first in SPI mode 0 (SCK idles low, the receiver samples on the rising edge and MOSI moves after the falling edge), SCK rests low for one more half period, and then the select line returns high for a programmable idle gap. A busy output covers the whole transfer, including the gap after the last byte. A commit that arrives while busy is dropped.

Top module: `spi_param_tx`

## Requirements
- R1: After reset, cs_n is high, sck is low and busy is low.
- R2: One accepted commit produces exactly six chip-select windows, each carrying exactly eight SCK rising edges. The byte order is amplitude, waveform, frequency pair 1, pair 2, pair 3, millions.
- R3: Digit k (k = 0 for units up to k = 6 for millions) sits in freq_digits[4k+3:4k]. Pair 1 = digit1·10 + digit0, pair 2 = digit3·10 + digit2, pair 3 = digit5·10 + digit4, and the last byte equals digit6.
- R4: Each byte is sent MSB first, and every bit is valid at the SCK rising edge that samples it.
- R5: SCK is low whenever cs_n is high, and it is low at each chip-select edge. MOSI does not change while SCK is high.
- R6: Every SCK high pulse and every low interval between two bits of a byte lasts HALF_CLKS clock cycles.
- R7: Between the end of one byte and the start of the next, cs_n stays high for at least GAP_CLKS cycles. This also holds across frames.
- R8: busy is high from the cycle after an accepted commit until the frame and its final gap are done. Input changes after the commit do not change the frame.
- R9: A commit that arrives while busy is high is ignored and adds no bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| commit | input | 1 | Start-frame strobe, accepted only while idle |
| amp_code | input | 8 | Amplitude byte |
| wave_code | input | 8 | Waveform selection byte |
| freq_digits | input | 28 | Seven BCD frequency digits, units in the lowest nibble |
| sck | output | 1 | SPI clock, idles low |
| mosi | output | 1 | SPI serial data, MSB first |
| cs_n | output | 1 | Active-low chip select, pulsed once per byte |
| busy | output | 1 | Frame transfer in progress |

## Verification
Frames are sent with several stimulus patterns. All-zero codes check that idle-low MOSI still frames eight edges per byte. All-nines digits with a saturated amplitude expose carries and the largest pair values (99 and 9). Alternating 0xA5/0x5A codes with mixed digits catch bit-order reversal and swapped digit pairs. Frames sent back to back check the inter-frame gap. In one frame the inputs are changed and a second commit is pulsed mid-transfer. Because the expected bytes are queued before that frame starts, any leak of the new values or any extra byte shows up as a mismatch or as an unexpected window.

// File: rtl/spi_param_tx.sv
module spi_param_tx #(
  parameter int HALF_CLKS = 6,
  parameter int GAP_CLKS  = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        commit,
  input  logic [7:0]  amp_code,
  input  logic [7:0]  wave_code,
  input  logic [27:0] freq_digits,
  output logic        sck,
  output logic        mosi,
  output logic        cs_n,
  output logic        busy
);
  localparam int NBYTES = 6;
  localparam int LAST_PHASE = 16;
  localparam int TMAX = (HALF_CLKS > GAP_CLKS) ? HALF_CLKS : GAP_CLKS;
  localparam int TW = $clog2(TMAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_GAP} st_t;

  st_t               st;
  logic [TW-1:0]     tick;
  logic [4:0]        phase;
  logic [2:0]        idx;
  logic [NBYTES-1:0][7:0] frame_q;
  logic [7:0]        cur_byte;

  function automatic logic [7:0] pack_pair(input logic [3:0] hi, input logic [3:0] lo);
    return {4'd0, hi} * 8'd10 + {4'd0, lo};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      tick    <= '0;
      phase   <= '0;
      idx     <= '0;
      frame_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (commit) begin
          frame_q[0] <= amp_code;
          frame_q[1] <= wave_code;
          frame_q[2] <= pack_pair(freq_digits[7:4],   freq_digits[3:0]);
          frame_q[3] <= pack_pair(freq_digits[15:12], freq_digits[11:8]);
          frame_q[4] <= pack_pair(freq_digits[23:20], freq_digits[19:16]);
          frame_q[5] <= {4'd0, freq_digits[27:24]};
          st    <= S_XFER;
          tick  <= '0;
          phase <= '0;
          idx   <= '0;
        end
        S_XFER: if (tick == TW'(HALF_CLKS - 1)) begin
          tick <= '0;
          if (phase == 5'(LAST_PHASE)) begin
            phase <= '0;
            st    <= S_GAP;
          end else begin
            phase <= phase + 5'd1;
          end
        end else begin
          tick <= tick + 1'b1;
        end
        S_GAP: if (tick == TW'(GAP_CLKS - 1)) begin
          tick <= '0;
          if (idx == 3'(NBYTES - 1)) begin
            st <= S_IDLE;
          end else begin
            idx <= idx + 3'd1;
            st  <= S_XFER;
          end
        end else begin
          tick <= tick + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign cur_byte = frame_q[idx];
  assign cs_n = (st != S_XFER);
  assign sck  = (st == S_XFER) && phase[0];
  assign mosi = (st == S_XFER) && !phase[4] && cur_byte[3'd7 - phase[3:1]];
  assign busy = (st != S_IDLE);
endmodule

// File: rtl/spi_param_tx_chk.sv
module spi_param_tx_chk #(
  parameter int HALF_CLKS = 6
) (
  input logic clk,
  input logic rst_n,
  input logic commit,
  input logic sck,
  input logic mosi,
  input logic cs_n,
  input logic busy
);
  logic [15:0] hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_run <= '0;
    else        hi_run <= sck ? hi_run + 16'd1 : 16'd0;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && !sck));

  assert_sck_low_deselect_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  assert_select_edge_sck_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> !sck);

  assert_mosi_hold_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));

  assert_sck_high_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sck) |-> (hi_run == 16'(HALF_CLKS)));

  assert_gap_min_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> cs_n);

  assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && commit) |=> busy);
endmodule

bind spi_param_tx spi_param_tx_chk #(.HALF_CLKS(HALF_CLKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .commit(commit), .sck(sck),
  .mosi(mosi), .cs_n(cs_n), .busy(busy)
);

// File: tb/spi_param_tx_bench.sv
module spi_param_tx_bench;
  localparam int HALF = 6;
  localparam int GAP  = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic commit = 1'b0;
  logic [7:0] amp_code = '0;
  logic [7:0] wave_code = '0;
  logic [27:0] freq_digits = '0;
  logic sck, mosi, cs_n, busy;

  int checks = 0;
  int failures = 0;
  int bytes_seen = 0;
  int bytes_expected = 0;
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;

  spi_param_tx #(.HALF_CLKS(HALF), .GAP_CLKS(GAP)) u_spi_param_tx (
    .clk(clk), .rst_n(rst_n), .commit(commit), .amp_code(amp_code),
    .wave_code(wave_code), .freq_digits(freq_digits),
    .sck(sck), .mosi(mosi), .cs_n(cs_n), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor
  logic p_sck = 1'b0, p_cs = 1'b1, p_mosi = 1'b0;
  logic [7:0] shreg = '0;
  int bitcnt = 0, hi_run = 0, lo_run = 0, cs_hi_run = 0;
  bit had_byte = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (sck && p_sck && (mosi != p_mosi)) check(0, "R5 mosi moved while sck high", mosi, p_mosi);
      if (cs_n && sck) check(0, "R5 sck high while deselected", sck, 0);
      if (!cs_n && p_cs) begin
        if (had_byte) check(cs_hi_run >= GAP, "R7 select gap", cs_hi_run, GAP);
        check(!sck, "R5 sck at select fall", sck, 0);
        bitcnt = 0;
        lo_run = 0;
      end
      if (!cs_n && sck && !p_sck) begin
        shreg = {shreg[6:0], mosi};
        if (bitcnt > 0) check(lo_run == HALF, "R6 low interval", lo_run, HALF);
        bitcnt++;
      end
      if (!sck && p_sck) check(hi_run == HALF, "R6 high pulse", hi_run, HALF);
      if (cs_n && !p_cs) begin
        had_byte = 1;
        bytes_seen++;
        check(!p_sck, "R5 sck at select rise", p_sck, 0);
        check(bitcnt == 8, "R2 edges per window", bitcnt, 8);
        if (exp_q.size() == 0) check(0, "R9 unexpected byte", shreg, -1);
        else begin
          automatic logic [7:0] e = exp_q.pop_front();
          check(shreg == e, "R2 R3 R4 byte value", shreg, e);
        end
      end
      hi_run    = sck ? hi_run + 1 : 0;
      lo_run    = (!sck && !cs_n) ? lo_run + 1 : 0;
      cs_hi_run = cs_n ? cs_hi_run + 1 : 0;
      p_sck = sck; p_cs = cs_n; p_mosi = mosi;
    end
  end

  function automatic logic [7:0] pr(input logic [3:0] hi, input logic [3:0] lo);
    return 8'(int'(hi) * 10 + int'(lo));
  endfunction

  task automatic send(input logic [7:0] a, input logic [7:0] w, input logic [27:0] d,
                      input bit disturb);
    exp_q.push_back(a);
    exp_q.push_back(w);
    exp_q.push_back(pr(d[7:4], d[3:0]));
    exp_q.push_back(pr(d[15:12], d[11:8]));
    exp_q.push_back(pr(d[23:20], d[19:16]));
    exp_q.push_back({4'd0, d[27:24]});
    bytes_expected += 6;
    @(negedge clk);
    amp_code = a; wave_code = w; freq_digits = d; commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
    check(busy == 1'b1, "R8 busy after commit", busy, 1);
    if (disturb) begin
      repeat (150) @(negedge clk);
      amp_code = ~a; wave_code = ~w; freq_digits = 28'h1234567;
      commit = 1'b1;
      @(negedge clk);
      commit = 1'b0;
      check(busy == 1'b1, "R9 still busy after ignored commit", busy, 1);
    end
    while (busy) @(negedge clk);
    check(exp_q.size() == 0, "R2 all bytes sent before busy drops", exp_q.size(), 0);
    check(cs_n == 1'b1, "R8 deselected at end", cs_n, 1);
  endtask

  initial begin
    #100000;
    check(0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cs_n == 1'b1, "R1 cs_n reset", cs_n, 1);
    check(sck == 1'b0, "R1 sck reset", sck, 0);
    check(busy == 1'b0, "R1 busy reset", busy, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(cs_n && !busy, "R1 idle after reset", busy, 0);
    send(8'h00, 8'h00, 28'h0000000, 0);
    send(8'hFF, 8'h03, 28'h9999999, 0);
    send(8'hA5, 8'h5A, 28'h5021874, 0);
    send(8'h0A, 8'h01, 28'h1000010, 1);
    send(8'h81, 8'h02, 28'h4999901, 0);
    repeat (300) @(negedge clk);
    check(bytes_seen == bytes_expected, "R9 byte total", bytes_seen, bytes_expected);
    check(!busy && cs_n, "R9 no frame from ignored commit", busy, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule